// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block rules on every write request aimed at a serial EEPROM-style device. A request targets either one byte address of a 1024-byte array or the status register. The block holds the two block-protect bits, the status-lock bit and the write-enable latch. It also samples an active-low protect pin. From these it issues a one-cycle grant or deny pulse. The serial shifting, the storage array and the write-cycle timing sit outside the block. They act on the grant pulse.

There are two protection levels. The software level covers a range of the array that the block-protect code selects. The hardware level applies when the status-lock bit is set and the synchronized pin is low. It does not matter which of the two happens first. The hardware level also freezes the status register. Raising the pin drops the block back to the software level, and the stored protect bits are kept. A granted status write loads the block-protect bits and the lock bit together. Every request, granted or denied, clears the write-enable latch.

Top module: `wp_ctrl`

## Requirements
- R1: After reset, grant_o and deny_o are 0, bp_o is 00, lock_o is 0, wel_o is 0 and mode_o is 0.
- R2: A cycle with wren_i high and no request sets wel_o on the next cycle. Any request, granted or denied, leaves wel_o at 0 on the next cycle.
- R3: A request made while the write-enable latch is 0 is denied, and it leaves bp_o and lock_o unchanged.
- R4: The block-protect code selects the protected array range. Code 00 protects nothing. Code 01 protects 0x300 to 0x3FF. Code 10 protects 0x200 to 0x3FF. Code 11 protects 0x000 to 0x3FF. With the latch set, an array write inside the range is denied and one outside it is granted.
- R5: mode_o encodes the protection level: 0 is open, 1 is software and 2 is hardware. It reads 2 when lock_o is 1 and the synchronized pin is low. Otherwise it reads 1 when bp_o is non-zero, and 0 when bp_o is zero. The lock bit and the pin low may arrive in either order.
- R6: The protect pin passes through a two-flop synchronizer. A pin change shows in mode_o after the second rising edge, and not after the first.
- R7: A status write with the latch set, made outside hardware mode, is granted. On the next cycle bp_o and lock_o hold the values bp_i and lock_i carried with the request.
- R8: In hardware mode, every status write is denied and bp_o and lock_o stay unchanged. Array writes follow the same ranges as in R4.
- R9: Driving the pin high while in hardware mode returns mode_o to the software level (or to open when bp_o is 00). bp_o stays unchanged.
- R10: Each request gives exactly one pulse on the cycle after it, either on grant_o or on deny_o, never both. Both outputs are 0 on a cycle that follows no request.
- R11: If wren_i and a request fall in the same cycle, the request is judged on the latch value held before that cycle, and the latch ends cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Protect pin, active low, asynchronous to clk_i |
| wren_i | input | 1 | Sets the write-enable latch |
| req_valid_i | input | 1 | Write request strobe |
| req_sts_i | input | 1 | 1: request targets the status register; 0: the array |
| req_addr_i | input | 10 | Array byte address |
| req_bp_i | input | 2 | Block-protect code to load on a status write |
| req_lock_i | input | 1 | Status-lock bit to load on a status write |
| grant_o | output | 1 | One-cycle grant pulse |
| deny_o | output | 1 | One-cycle deny pulse |
| mode_o | output | 2 | Protection level (0 open, 1 software, 2 hardware) |
| bp_o | output | 2 | Stored block-protect code |
| lock_o | output | 1 | Stored status-lock bit |
| wel_o | output | 1 | Write-enable latch |

## Verification
Setting the write-enable latch and judging a request can fall in the same clock cycle. The bench provokes this by raising wren_i in the very cycle of a request. It does this once with the latch clear and once with it set. A correct result is a deny in the first case and a grant in the second, with wel_o cleared afterwards in both. This shows that the request reads the latch's earlier value and that the clear takes priority over the set.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BP_W = 2;

  typedef enum logic [1:0] {
    MODE_OPEN = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_HARD = 2'd2
  } wp_mode_e;
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wp_range.sv
module wp_range
  import wp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [BP_W-1:0]   bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned HALF_BASE = 1 << (ADDR_W - 1);
  localparam int unsigned QTR_BASE  = 3 * (1 << (ADDR_W - 2));
  localparam logic [ADDR_W-1:0] HALF_A = HALF_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] QTR_A  = QTR_BASE[ADDR_W-1:0];

  always_comb begin
    unique case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = (addr_i >= QTR_A);
      2'b10:   hit_o = (addr_i >= HALF_A);
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status.sv
module wp_status
  import wp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wren_i,
  input  logic            req_i,
  input  logic            sts_load_i,
  input  logic [BP_W-1:0] bp_d_i,
  input  logic            lock_d_i,
  output logic [BP_W-1:0] bp_o,
  output logic            lock_o,
  output logic            wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_o   <= '0;
      lock_o <= 1'b0;
    end else if (sts_load_i) begin
      bp_o   <= bp_d_i;
      lock_o <= lock_d_i;
    end
  end

  // a request always clears the latch, even when wren_i arrives with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wel_o <= 1'b0;
    else if (req_i)  wel_o <= 1'b0;
    else if (wren_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              wren_i,
  input  logic              req_valid_i,
  input  logic              req_sts_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BP_W-1:0]   req_bp_i,
  input  logic              req_lock_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [1:0]        mode_o,
  output logic [BP_W-1:0]   bp_o,
  output logic              lock_o,
  output logic              wel_o
);
  logic     pin_hi;
  logic     hard;
  logic     in_range;
  logic     allow;
  logic     sts_load;
  wp_mode_e mode;

  wp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wp_ni),
    .q_o   (pin_hi)
  );

  wp_range #(.ADDR_W(ADDR_W)) u_range (
    .bp_i  (bp_o),
    .addr_i(req_addr_i),
    .hit_o (in_range)
  );

  assign hard     = lock_o & ~pin_hi;
  assign allow    = wel_o & (req_sts_i ? ~hard : ~in_range);
  assign sts_load = req_valid_i & req_sts_i & allow;

  wp_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wren_i    (wren_i),
    .req_i     (req_valid_i),
    .sts_load_i(sts_load),
    .bp_d_i    (req_bp_i),
    .lock_d_i  (req_lock_i),
    .bp_o      (bp_o),
    .lock_o    (lock_o),
    .wel_o     (wel_o)
  );

  always_comb begin
    if (hard)             mode = MODE_HARD;
    else if (bp_o != '0)  mode = MODE_SOFT;
    else                  mode = MODE_OPEN;
  end
  assign mode_o = mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= req_valid_i & allow;
      deny_o  <= req_valid_i & ~allow;
    end
  end
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wren_i,
  input logic       req_valid_i,
  input logic       req_sts_i,
  input logic [1:0] req_bp_i,
  input logic       req_lock_i,
  input logic       grant_o,
  input logic       deny_o,
  input logic [1:0] mode_o,
  input logic [1:0] bp_o,
  input logic       lock_o,
  input logic       wel_o
);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));
  a_r10_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (grant_o || deny_o));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!grant_o && !deny_o));
  a_r2_wel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !wel_o);
  a_r2_wel_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !req_valid_i) |=> wel_o);
  a_r3_no_latch_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wel_o) |=> (deny_o && $stable(bp_o) && $stable(lock_o)));
  a_r8_hard_locks_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_sts_i && mode_o == 2'd2) |=>
      (deny_o && $stable(bp_o) && $stable(lock_o)));
  a_r7_sts_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_sts_i && wel_o && mode_o != 2'd2) |=>
      (grant_o && bp_o == $past(req_bp_i) && lock_o == $past(req_lock_i)));
  a_r9_bp_only_by_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_sts_i) |=> ($stable(bp_o) && $stable(lock_o)));
  a_r5_hard_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> lock_o);
endmodule

bind wp_ctrl wp_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wren_i     (wren_i),
  .req_valid_i(req_valid_i),
  .req_sts_i  (req_sts_i),
  .req_bp_i   (req_bp_i),
  .req_lock_i (req_lock_i),
  .grant_o    (grant_o),
  .deny_o     (deny_o),
  .mode_o     (mode_o),
  .bp_o       (bp_o),
  .lock_o     (lock_o),
  .wel_o      (wel_o)
);

// File: tb/tb_wp_ctrl.sv
module tb_wp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int NVEC       = 10;

  // {bp[1:0], addr[9:0], expected grant}
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b00, 10'h3FF, 1'b1},
    {2'b01, 10'h2FF, 1'b1},
    {2'b01, 10'h300, 1'b0},
    {2'b01, 10'h3FF, 1'b0},
    {2'b10, 10'h1FF, 1'b1},
    {2'b10, 10'h200, 1'b0},
    {2'b11, 10'h000, 1'b0},
    {2'b11, 10'h3FF, 1'b0},
    {2'b00, 10'h000, 1'b1},
    {2'b00, 10'h200, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wp_ni = 1'b1;
  logic wren_i = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_sts_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0] req_bp_i = '0;
  logic req_lock_i = 1'b0;
  logic grant_o, deny_o, lock_o, wel_o;
  logic [1:0] mode_o, bp_o;

  int n_chk = 0;
  int n_fail = 0;
  logic g, d;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wp_ni(wp_ni), .wren_i(wren_i),
    .req_valid_i(req_valid_i), .req_sts_i(req_sts_i), .req_addr_i(req_addr_i),
    .req_bp_i(req_bp_i), .req_lock_i(req_lock_i), .grant_o(grant_o),
    .deny_o(deny_o), .mode_o(mode_o), .bp_o(bp_o), .lock_o(lock_o), .wel_o(wel_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_wel();
    @(negedge clk); wren_i = 1'b1;
    @(negedge clk); wren_i = 1'b0;
  endtask

  task automatic do_req(input logic sts, input logic [ADDR_W-1:0] a,
                        input logic [1:0] bp, input logic lk, input logic wr,
                        output logic gr, output logic dn);
    @(negedge clk);
    req_valid_i = 1'b1; req_sts_i = sts; req_addr_i = a;
    req_bp_i = bp; req_lock_i = lk; wren_i = wr;
    @(negedge clk);
    gr = grant_o; dn = deny_o;
    req_valid_i = 1'b0; wren_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 grant", int'(grant_o), 0);
    check("R1 deny", int'(deny_o), 0);
    check("R1 bp", int'(bp_o), 0);
    check("R1 lock", int'(lock_o), 0);
    check("R1 wel", int'(wel_o), 0);
    check("R1 mode", int'(mode_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R3: no latch -> deny, state kept
    do_req(1'b1, '0, 2'b11, 1'b1, 1'b0, g, d);
    check("R3 deny", int'(d), 1);
    check("R3 grant", int'(g), 0);
    check("R3 bp kept", int'(bp_o), 0);
    check("R3 lock kept", int'(lock_o), 0);

    // R2: latch set and cleared
    set_wel();
    check("R2 wel set", int'(wel_o), 1);
    do_req(1'b0, 10'h010, 2'b00, 1'b0, 1'b0, g, d);
    check("R2 wel cleared", int'(wel_o), 0);
    check("R10 pulse one", int'(g ^ d), 1);
    @(negedge clk);
    check("R10 grant pulse ends", int'(grant_o), 0);
    check("R10 deny quiet", int'(deny_o), 0);

    // R4: range table
    for (int i = 0; i < NVEC; i++) begin
      set_wel();
      do_req(1'b1, '0, VEC[i][12:11], 1'b0, 1'b0, g, d);
      check("R7 setup bp", int'(bp_o), int'(VEC[i][12:11]));
      set_wel();
      do_req(1'b0, VEC[i][10:1], 2'b00, 1'b0, 1'b0, g, d);
      check("R4 grant", int'(g), int'(VEC[i][0]));
      check("R4 deny", int'(d), int'(!VEC[i][0]));
    end

    // R7 + R5: load bp and lock together, pin high -> soft
    set_wel();
    do_req(1'b1, '0, 2'b01, 1'b1, 1'b0, g, d);
    check("R7 grant", int'(g), 1);
    check("R7 bp", int'(bp_o), 1);
    check("R7 lock", int'(lock_o), 1);
    check("R5 soft", int'(mode_o), 1);

    // R6: pin low seen after second edge
    @(negedge clk); wp_ni = 1'b0;
    @(negedge clk);
    check("R6 one edge", int'(mode_o), 1);
    @(negedge clk);
    check("R6 two edges", int'(mode_o), 2);

    // R8: hardware mode
    set_wel();
    do_req(1'b1, '0, 2'b00, 1'b0, 1'b0, g, d);
    check("R8 sts deny", int'(d), 1);
    check("R8 bp kept", int'(bp_o), 1);
    check("R8 lock kept", int'(lock_o), 1);
    set_wel();
    do_req(1'b0, 10'h100, 2'b00, 1'b0, 1'b0, g, d);
    check("R8 array open", int'(g), 1);
    set_wel();
    do_req(1'b0, 10'h300, 2'b00, 1'b0, 1'b0, g, d);
    check("R8 array range", int'(d), 1);

    // R9: pin high -> back to soft
    @(negedge clk); wp_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 mode soft", int'(mode_o), 1);
    check("R9 bp kept", int'(bp_o), 1);

    // R5: other order, pin low first then lock
    set_wel();
    do_req(1'b1, '0, 2'b01, 1'b0, 1'b0, g, d);
    check("R5 unlock", int'(lock_o), 0);
    @(negedge clk); wp_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 pin low no lock", int'(mode_o), 1);
    set_wel();
    do_req(1'b1, '0, 2'b00, 1'b1, 1'b0, g, d);
    check("R5 lock grant", int'(g), 1);
    check("R5 hard after lock", int'(mode_o), 2);
    @(negedge clk); wp_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 open when bp 00", int'(mode_o), 0);

    // R11: wren with request in the same cycle
    do_req(1'b0, 10'h000, 2'b00, 1'b0, 1'b1, g, d);
    check("R11 old latch deny", int'(d), 1);
    check("R11 latch cleared", int'(wel_o), 0);
    set_wel();
    do_req(1'b0, 10'h000, 2'b00, 1'b0, 1'b1, g, d);
    check("R11 old latch grant", int'(g), 1);
    check("R11 latch cleared again", int'(wel_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule